// File: doc/BRIEF.md
# Staged DAC Word Register

This block builds a 12-bit unsigned converter code from two byte-wide bus writes and drives it to a digital-to-analog converter port. The bus is eight bits wide, so the code arrives in two parts. A write to the low strobe stores bits 7..0 in a staging register and has no other effect. A write to the high strobe supplies bits 11..8 and commits the whole code. Software writes the low byte first and the high byte second.

The commit can happen in one of two ways. With simultaneous mode off, the high write moves the code to the output register, which changes on the next clock. With simultaneous mode on, the code waits in a one-entry pending slot until a global update strobe arrives. That strobe lets several converter channels change on the same clock edge. Each commit raises `dac_load` for one cycle, and the converter is expected to latch `dac_code` on that cycle. The output is a qualified word with no ready signal: the converter takes every load, so there is no back-pressure. The address decoder and the analog part are outside this block.

Top module: `staged_dac_word`

## Requirements
- R1: During reset `dac_code` is 0, `dac_load` is 0 and the staged low byte is 0. A high write straight after reset, with data 0x05 and simultaneous mode off, gives `dac_code` 0x500.
- R2: A low write (`wr_lo`=1, `wr_hi`=0) stores `din` as code bits 7..0. It leaves `dac_code` unchanged and raises no `dac_load`.
- R3: When `sim_en`=0, a high write gives `dac_code` = {`din[3:0]`, staged low byte} one cycle later, with `dac_load` high for that one cycle. The staged low byte is kept for later high writes.
- R4: During a high write, `din[7:4]` has no effect on the code.
- R5: When `sim_en`=1, a high write puts the combined code in the pending slot and marks the slot full. `dac_code` stays unchanged and no `dac_load` is raised.
- R6: When `upd`=1 and the pending slot is full, the next cycle shows the pending code on `dac_code` with a one-cycle `dac_load`, and the slot becomes empty. This works whatever the state of `sim_en`. A second `upd` before another deferred high write has no effect.
- R7: `upd` has no effect on `dac_code` or `dac_load` while the pending slot is empty.
- R8: If `upd` and a deferred high write (`sim_en`=1) fall in the same cycle, the code that was already pending is committed. The new code becomes the pending code.
- R9: If `wr_lo` and `wr_hi` are both high, the bus byte is used only as the high byte and the staged low byte does not change.
- R10: If a direct high write (`sim_en`=0) and `upd` fall in the same cycle while a code is pending, the direct write goes to the output. The pending code stays for a later `upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Bus write data |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe (commit) |
| sim_en | input | 1 | Simultaneous mode: high writes defer to `upd` |
| upd | input | 1 | Global update strobe |
| dac_code | output | 12 | Code presented to the converter |
| dac_load | output | 1 | One-cycle pulse for each commit |

## Verification
Two pairs of events can fall in the same cycle. An update strobe can meet a deferred high write, and an update strobe can meet a direct high write while a code is pending. Both pairs are forced by directed sequences. The random phase, driven by a fixed seed, also hits them many times, because it draws the strobes independently and toggles the mode. Each cycle the bench compares `dac_code` and `dac_load` with a reference model. Each collision is then judged by a trailing update strobe that shows which code was left in the pending slot.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned CODE_W = 12;

  // how a cycle's strobes resolve onto the output register
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_DIRECT = 2'd1,
    SRC_PEND   = 2'd2
  } out_src_e;
endpackage

// File: rtl/dacw_stage.sv
module dacw_stage #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] din,
  input  logic             wr_lo,
  input  logic             wr_hi,
  output logic [BUS_W-1:0] lo_q
);
  // a simultaneous high write claims the shared bus byte
  logic take;
  assign take = wr_lo & ~wr_hi;

  always_ff @(posedge clk) begin
    if (rst)       lo_q <= '0;
    else if (take) lo_q <= din;
  end
endmodule

// File: rtl/dacw_pend.sv
module dacw_pend #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              defer_wr,
  input  logic              direct_wr,
  input  logic              upd,
  input  logic [CODE_W-1:0] new_code,
  output logic [CODE_W-1:0] pend_code,
  output logic              pend_v,
  output logic              fire
);
  // a direct write owns the output this cycle; pending waits
  assign fire = upd & pend_v & ~direct_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code <= '0;
      pend_v    <= 1'b0;
    end else if (defer_wr) begin
      pend_code <= new_code;
      pend_v    <= 1'b1;
    end else if (fire) begin
      pend_v    <= 1'b0;
    end
  end
endmodule

// File: rtl/dacw_out.sv
module dacw_out
  import dacw_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              direct_wr,
  input  logic [CODE_W-1:0] direct_code,
  input  logic              fire,
  input  logic [CODE_W-1:0] pend_code,
  output logic [CODE_W-1:0] code_q,
  output logic              load_q
);
  out_src_e src;

  always_comb begin
    if (direct_wr) src = SRC_DIRECT;
    else if (fire) src = SRC_PEND;
    else           src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= (src != SRC_HOLD);
      case (src)
        SRC_DIRECT: code_q <= direct_code;
        SRC_PEND:   code_q <= pend_code;
        default:    code_q <= code_q;
      endcase
    end
  end
endmodule

// File: rtl/staged_dac_word.sv
module staged_dac_word #(
  parameter int unsigned BUS_W  = dacw_pkg::BUS_W,
  parameter int unsigned CODE_W = dacw_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  din,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              sim_en,
  input  logic              upd,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load
);
  localparam int unsigned HI_W = CODE_W - BUS_W;

  logic [BUS_W-1:0]  lo_q;
  logic [CODE_W-1:0] new_code;
  logic [CODE_W-1:0] pend_code;
  logic              pend_v;
  logic              fire;
  logic              direct_wr;
  logic              defer_wr;

  assign direct_wr = wr_hi & ~sim_en;
  assign defer_wr  = wr_hi &  sim_en;
  assign new_code  = {din[HI_W-1:0], lo_q};

  dacw_stage #(.BUS_W(BUS_W)) u_stage (
    .clk(clk), .rst(rst), .din(din), .wr_lo(wr_lo), .wr_hi(wr_hi), .lo_q(lo_q)
  );

  dacw_pend #(.CODE_W(CODE_W)) u_pend (
    .clk(clk), .rst(rst), .defer_wr(defer_wr), .direct_wr(direct_wr), .upd(upd),
    .new_code(new_code), .pend_code(pend_code), .pend_v(pend_v), .fire(fire)
  );

  dacw_out #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .direct_wr(direct_wr), .direct_code(new_code),
    .fire(fire), .pend_code(pend_code), .code_q(dac_code), .load_q(dac_load)
  );
endmodule

// File: rtl/staged_dac_word_chk.sv
module staged_dac_word_chk #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_W-1:0]  din,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              sim_en,
  input logic              upd,
  input logic [BUS_W-1:0]  lo_q,
  input logic [CODE_W-1:0] pend_code,
  input logic              pend_v,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_load
);
  localparam int unsigned HI_W = CODE_W - BUS_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !dac_load));

  // R2
  lo_only_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi && !(upd && pend_v)) |=> ($stable(dac_code) && !dac_load));

  // R3
  direct_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !sim_en) |=> (dac_load && dac_code == {$past(din[HI_W-1:0]), $past(lo_q)}));

  // R5
  sim_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && sim_en && !(upd && pend_v)) |=> ($stable(dac_code) && !dac_load));

  // R6
  upd_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && pend_v && !(wr_hi && !sim_en)) |=> (dac_load && dac_code == $past(pend_code)));

  // R7
  load_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> ($past(wr_hi && !sim_en) || $past(upd && pend_v)));
endmodule

bind staged_dac_word staged_dac_word_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .din(din), .wr_lo(wr_lo), .wr_hi(wr_hi), .sim_en(sim_en),
  .upd(upd), .lo_q(lo_q), .pend_code(pend_code), .pend_v(pend_v),
  .dac_code(dac_code), .dac_load(dac_load)
);

// File: tb/test_staged_dac_word.sv
`timescale 1ns/1ps
module test_staged_dac_word;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  din = '0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0, sim_en = 1'b0, upd = 1'b0;
  logic [11:0] dac_code;
  logic        dac_load;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0]  m_lo = '0;
  logic [11:0] m_pend = '0, m_code = '0;
  logic        m_pv = 1'b0, m_load = 1'b0;

  always #2.5 clk = ~clk;

  staged_dac_word i_staged_dac_word (
    .clk(clk), .rst(rst), .din(din), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .sim_en(sim_en), .upd(upd), .dac_code(dac_code), .dac_load(dac_load)
  );

  function automatic logic [11:0] join_code(logic [7:0] hi_byte, logic [7:0] lo_byte);
    return {hi_byte[3:0], lo_byte};
  endfunction

  task automatic model_step();
    logic direct, fire;
    logic [11:0] nc;
    nc     = join_code(din, m_lo);
    direct = wr_hi && !sim_en;
    fire   = upd && m_pv && !direct;
    m_load = direct || fire;
    if (direct)    m_code = nc;
    else if (fire) m_code = m_pend;
    if (wr_hi && sim_en) begin m_pend = nc; m_pv = 1'b1; end
    else if (fire)       m_pv = 1'b0;
    if (wr_lo && !wr_hi) m_lo = din;
  endtask

  task automatic compare(string tag);
    checks++;
    if (dac_code !== m_code || dac_load !== m_load) begin
      fails++;
      $display("FAIL %s: code=%h load=%b expected code=%h load=%b",
               tag, dac_code, dac_load, m_code, m_load);
    end
  endtask

  task automatic cyc(string tag, logic lo, logic hi, logic sm, logic up, logic [7:0] d);
    wr_lo = lo; wr_hi = hi; sim_en = sm; upd = up; din = d;
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    compare("R1");                        // held in reset
    rst = 1'b0;
    cyc("R1", 0, 0, 0, 0, 8'h00);
    cyc("R1", 0, 1, 0, 0, 8'h05);         // 0x500
    cyc("R2", 1, 0, 0, 0, 8'hA7);
    cyc("R2", 0, 0, 0, 0, 8'h00);
    cyc("R3", 0, 1, 0, 0, 8'h03);         // 0x3A7
    cyc("R3", 0, 0, 0, 0, 8'h00);         // pulse ends
    cyc("R4", 0, 1, 0, 0, 8'hF9);         // 0x9A7
    cyc("R9", 1, 1, 0, 0, 8'h42);         // 0x2A7, low kept
    cyc("R9", 0, 1, 0, 0, 8'h01);         // 0x1A7
    cyc("R5", 1, 0, 1, 0, 8'h11);
    cyc("R5", 0, 1, 1, 0, 8'h06);         // pending 0x611
    cyc("R6", 0, 0, 1, 1, 8'h00);         // 0x611
    cyc("R6", 0, 0, 1, 1, 8'h00);         // slot empty now
    cyc("R7", 0, 0, 0, 1, 8'h00);
    cyc("R8", 0, 1, 1, 0, 8'h02);         // pending 0x211
    cyc("R8", 0, 1, 1, 1, 8'h0C);         // out 0x211, pending 0xC11
    cyc("R8", 0, 0, 1, 1, 8'h00);         // out 0xC11
    cyc("R10", 0, 1, 1, 0, 8'h07);        // pending 0x711
    cyc("R10", 0, 1, 0, 1, 8'h0D);        // out 0xD11, pending kept
    cyc("R10", 0, 0, 0, 1, 8'h00);        // out 0x711
    void'($urandom(32'h5EED_0D1A));
    begin
      logic sm = 1'b0;
      for (int n = 0; n < 4000; n++) begin
        logic lo, hi, up;
        string tag;
        if ($urandom_range(15) == 0) sm = ~sm;
        lo = ($urandom_range(9) < 3);
        hi = ($urandom_range(9) < 3);
        up = ($urandom_range(9) < 3);
        if (hi && !sm)      tag = "R3";
        else if (hi && up)  tag = "R8";
        else if (hi)        tag = "R5";
        else if (up)        tag = "R6";
        else if (lo)        tag = "R2";
        else                tag = "R7";
        cyc(tag, lo, hi, sm, up, 8'($urandom));
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule